// File: doc/BRIEF.md
# Instruction fetch fault trap capture

This block sits at the issue point of a machine-mode-only core with 16-bit and 32-bit instructions. Every cycle it may be handed one instruction that is starting, together with:

- its PC and its length;
- a fetch permission verdict for each 16-bit portion, supplied by an external physical protection checker;
- when the instruction is a taken branch or jump, the target address and a flag saying whether that target is misaligned.

From these inputs the block decides whether the instruction traps, and for which cause. An instruction whose own bytes cannot be fetched takes an access fault, with cause 1. In that case the trap PC register holds the instruction start, and the trap value register holds the address of the first portion that failed. A taken branch whose target is misaligned takes a misaligned-target fault, with cause 0. That fault is charged to the branch itself, so the trap PC register holds the branch address and the trap value register holds the target.

A trapping instruction does not retire and does not write its destination register. Fetch is redirected to the trap vector base in the same cycle. Both address registers are 41 bits wide, sized for a 40-bit implemented address space. An address at or above 2^40 is stored with bit 40 set and its low 40 bits kept. The stored value is read out zero-extended to 64 bits.

Top module: `fetch_trap_capture`

## Requirements
- R1: After reset, the trap PC, trap value and cause outputs read zero, and the trap output is low.
- R2: If the first portion of an instruction is not permitted (`lo_ok`=0), the instruction traps. On the next cycle, the trap PC and trap value registers both hold its PC and the cause reads 1.
- R3: If a 32-bit instruction (`is_long`=1) has a permitted first portion but a forbidden second portion, it traps. The trap PC register holds its PC, the trap value register holds PC+2, and the cause reads 1.
- R4: If both portions of a 32-bit instruction are forbidden, the trap value register holds the instruction start address.
- R5: A 16-bit instruction (`is_long`=0) ignores `hi_ok`. With `lo_ok`=1 it retires and the registers keep their values.
- R6: A taken branch with a misaligned target (`br_taken`=1, `br_misal`=1) traps. On the next cycle the cause reads 0, the trap PC register holds the branch PC, and the trap value register holds the target.
- R7: An instruction whose own fetch fails traps with cause 1 even when the branch inputs are asserted.
- R8: In a trap cycle, `retire` and `wb_en` are low, `redir_valid` is high, and `redir_pc` equals `mtvec`.
- R9: A non-trapping valid instruction asserts `retire`, drives `wb_en` equal to `wb_req`, and leaves the registers unchanged. A taken branch with an aligned target redirects to that target.
- R10: An address at or above 2^40 is stored as 2^40 plus the address modulo 2^40 and is read out with bit 40 set. An address below 2^40 reads back unchanged.
- R11: With execution permitted only below 0x00100000, the instruction at 0x000ffffc retires. The next instruction, at 0x00100000, traps with trap PC = trap value = 0x00100000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction starts this cycle |
| iss_pc | input | 64 | Start address of the instruction |
| is_long | input | 1 | 1 = 32-bit instruction, 0 = 16-bit |
| lo_ok | input | 1 | Fetch of the portion at PC is permitted |
| hi_ok | input | 1 | Fetch of the portion at PC+2 is permitted |
| br_taken | input | 1 | Instruction is a taken branch or jump |
| br_target | input | 64 | Branch or jump target |
| br_misal | input | 1 | Target is misaligned |
| wb_req | input | 1 | Instruction wants a register write |
| mtvec | input | 64 | Trap vector base address |
| retire | output | 1 | Instruction retires |
| wb_en | output | 1 | Register write allowed |
| trap | output | 1 | Instruction traps |
| redir_valid | output | 1 | Fetch redirect requested |
| redir_pc | output | 64 | Redirect address |
| mepc_rd | output | 64 | Trap PC register, zero-extended |
| mtval_rd | output | 64 | Trap value register, zero-extended |
| mcause_rd | output | 64 | Trap cause register |

## Verification
The assertions assume that `iss_pc` is always halfword-aligned and that the protection checker's verdicts are valid whenever `iss_valid` is high. The checks on the captured address register values rely on both of these assumptions. Every scenario task drives only even PCs. Branch misalignment is signalled only through `br_misal`, so the targets in the stimulus may be odd without ever reaching the trap PC register.

// File: rtl/fetch_trap_capture.sv
module fetch_trap_capture #(
  parameter int XLEN  = 64,
  parameter int PABITS = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_valid,
  input  logic [XLEN-1:0] iss_pc,
  input  logic            is_long,
  input  logic            lo_ok,
  input  logic            hi_ok,
  input  logic            br_taken,
  input  logic [XLEN-1:0] br_target,
  input  logic            br_misal,
  input  logic            wb_req,
  input  logic [XLEN-1:0] mtvec,
  output logic            retire,
  output logic            wb_en,
  output logic            trap,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc,
  output logic [XLEN-1:0] mepc_rd,
  output logic [XLEN-1:0] mtval_rd,
  output logic [XLEN-1:0] mcause_rd
);
  localparam int RW = PABITS + 1;

  function automatic logic [RW-1:0] recode(input logic [XLEN-1:0] a);
    recode = {(a[XLEN-1:PABITS] != '0), a[PABITS-1:0]};
  endfunction

  logic [RW-1:0] mepc_q, mtval_q;
  logic          cause_q;

  wire acc_fault = iss_valid && (!lo_ok || (is_long && !hi_ok));
  wire mis_fault = iss_valid && !acc_fault && br_taken && br_misal;
  wire [XLEN-1:0] fault_addr = !lo_ok ? iss_pc : iss_pc + XLEN'(2);

  assign trap        = acc_fault || mis_fault;
  assign retire      = iss_valid && !trap;
  assign wb_en       = retire && wb_req;
  assign redir_valid = trap || (retire && br_taken);
  assign redir_pc    = trap ? mtvec : br_target;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mepc_q  <= '0;
      mtval_q <= '0;
      cause_q <= 1'b0;
    end else if (acc_fault) begin
      mepc_q  <= recode(iss_pc);
      mtval_q <= recode(fault_addr);
      cause_q <= 1'b1;
    end else if (mis_fault) begin
      mepc_q  <= recode(iss_pc);
      mtval_q <= recode(br_target);
      cause_q <= 1'b0;
    end
  end

  assign mepc_rd   = XLEN'(mepc_q);
  assign mtval_rd  = XLEN'(mtval_q);
  assign mcause_rd = XLEN'(cause_q);

  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap, retire}));
  // R8
  trap_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (redir_valid && redir_pc == mtvec && !wb_en));
  // R2
  acc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !lo_ok) |=> (mcause_rd == XLEN'(1) && mepc_rd == mtval_rd));
  // R6
  mis_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && lo_ok && (!is_long || hi_ok) && br_taken && br_misal)
      |=> (mcause_rd == '0 && mepc_rd[0] == 1'b0));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && $past(rst_n)) |=> ($stable(mepc_rd) && $stable(mtval_rd)));
endmodule

// File: tb/fetch_trap_capture_test.sv
module fetch_trap_capture_test;
  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, is_long = 0, lo_ok = 1, hi_ok = 1;
  logic br_taken = 0, br_misal = 0, wb_req = 0;
  logic [63:0] iss_pc = 0, br_target = 0, mtvec = 64'h8000_0100;
  logic retire, wb_en, trap, redir_valid;
  logic [63:0] redir_pc, mepc_rd, mtval_rd, mcause_rd;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  fetch_trap_capture uut (.*);

  task automatic chk(input string req, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] pc, input logic lng, lo, hi,
                       input logic bt, input logic [63:0] tgt, input logic bm, wr);
    @(negedge clk);
    iss_valid = 1; iss_pc = pc; is_long = lng; lo_ok = lo; hi_ok = hi;
    br_taken = bt; br_target = tgt; br_misal = bm; wb_req = wr;
    #1;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    iss_valid = 0; br_taken = 0; br_misal = 0; wb_req = 0;
    #1;
  endtask

  task automatic t_reset();
    chk("R1 mepc", mepc_rd, 0);
    chk("R1 mtval", mtval_rd, 0);
    chk("R1 mcause", mcause_rd, 0);
    chk("R1 trap", {63'd0, trap}, 0);
  endtask

  task automatic t_first_portion();
    drive(64'h2000, 1, 0, 1, 0, 0, 0, 1);
    chk("R2 trap", {63'd0, trap}, 1);
    chk("R8 retire", {63'd0, retire}, 0);
    chk("R8 wb_en", {63'd0, wb_en}, 0);
    chk("R8 redir_valid", {63'd0, redir_valid}, 1);
    chk("R8 redir_pc", redir_pc, mtvec);
    idle();
    chk("R2 mepc", mepc_rd, 64'h2000);
    chk("R2 mtval", mtval_rd, 64'h2000);
    chk("R2 mcause", mcause_rd, 1);
  endtask

  task automatic t_straddle();
    drive(64'h3ffe, 1, 1, 0, 0, 0, 0, 0);
    chk("R3 trap", {63'd0, trap}, 1);
    idle();
    chk("R3 mepc", mepc_rd, 64'h3ffe);
    chk("R3 mtval", mtval_rd, 64'h4000);
    chk("R3 mcause", mcause_rd, 1);
  endtask

  task automatic t_both();
    drive(64'h5004, 1, 0, 0, 0, 0, 0, 0);
    idle();
    chk("R4 mtval", mtval_rd, 64'h5004);
    chk("R4 mepc", mepc_rd, 64'h5004);
  endtask

  task automatic t_short_ignores_hi();
    drive(64'h6002, 0, 1, 0, 0, 0, 0, 1);
    chk("R5 retire", {63'd0, retire}, 1);
    chk("R5 trap", {63'd0, trap}, 0);
    idle();
    chk("R5 mepc kept", mepc_rd, 64'h5004);
  endtask

  task automatic t_misaligned();
    drive(64'h7000, 1, 1, 1, 1, 64'h7101, 1, 1);
    chk("R6 trap", {63'd0, trap}, 1);
    chk("R6 wb_en", {63'd0, wb_en}, 0);
    idle();
    chk("R6 mcause", mcause_rd, 0);
    chk("R6 mepc", mepc_rd, 64'h7000);
    chk("R6 mtval", mtval_rd, 64'h7101);
  endtask

  task automatic t_priority();
    drive(64'h8000, 0, 0, 1, 1, 64'h9003, 1, 0);
    idle();
    chk("R7 mcause", mcause_rd, 1);
    chk("R7 mtval", mtval_rd, 64'h8000);
  endtask

  task automatic t_normal();
    drive(64'ha000, 1, 1, 1, 1, 64'hb000, 0, 1);
    chk("R9 retire", {63'd0, retire}, 1);
    chk("R9 wb_en", {63'd0, wb_en}, 1);
    chk("R9 redir_valid", {63'd0, redir_valid}, 1);
    chk("R9 redir_pc", redir_pc, 64'hb000);
    idle();
    chk("R9 mepc kept", mepc_rd, 64'h8000);
    drive(64'ha004, 0, 1, 1, 0, 0, 0, 0);
    chk("R9 wb_en follows", {63'd0, wb_en}, 0);
    chk("R9 no redirect", {63'd0, redir_valid}, 0);
    idle();
  endtask

  task automatic t_recode();
    drive(64'h0000_00ff_ffff_fffe, 1, 1, 0, 0, 0, 0, 0);
    idle();
    chk("R10 mepc below", mepc_rd, 64'h0000_00ff_ffff_fffe);
    chk("R10 mtval at 2^40", mtval_rd, 64'h0000_0100_0000_0000);
    drive(64'h1234_5600_0000_1230, 0, 0, 1, 0, 0, 0, 0);
    idle();
    chk("R10 mepc recoded", mepc_rd, 64'h0000_0100_0000_1230);
    drive(64'h100, 0, 1, 1, 1, 64'hffff_ff00_0000_0003, 1, 0);
    idle();
    chk("R10 mtval recoded", mtval_rd, 64'h0000_0100_0000_0003);
  endtask

  task automatic t_boundary();
    drive(64'h000f_fffc, 1, 1, 1, 0, 0, 0, 1);
    chk("R11 retire prior", {63'd0, retire}, 1);
    chk("R11 wb prior", {63'd0, wb_en}, 1);
    idle();
    drive(64'h0010_0000, 1, 0, 0, 0, 0, 0, 1);
    chk("R11 trap", {63'd0, trap}, 1);
    idle();
    chk("R11 mepc", mepc_rd, 64'h0010_0000);
    chk("R11 mtval", mtval_rd, 64'h0010_0000);
    chk("R11 mcause", mcause_rd, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1;
    t_first_portion();
    t_straddle();
    t_both();
    t_short_ignores_hi();
    t_misaligned();
    t_priority();
    t_normal();
    t_recode();
    t_boundary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule